// File: doc/BRIEF.md
# Serial EEPROM Bus Slave

This block is the target side of a two-wire serial bus (clock line plus open-drain data line) with a 1024-byte, 8-bit-wide memory behind it. The memory is held in ordinary flip-flops. A bus master addresses the block with a device byte. The block then decodes a word address and data bytes and acknowledges each byte it accepts. It supplies read data by pulling the data line low through an output enable.

Both bus lines are first synchronized to the system clock and then filtered against glitches. Start and stop conditions are derived from the filtered lines. A single 10-bit address pointer serves every transfer type. Writes advance the pointer only inside a 16-byte row. Reads advance it across the whole array, and the pointer keeps its value from one transaction to the next. After a stop that closes a write, the block ignores its own device address for a fixed number of clocks. This models the internal programming time, and a master can poll for it.

Top module: `twi_eeprom_slave`

## Requirements
- R1: The device byte is decoded MSB first. Bits 7:3 must equal 5'b10100. In a write, bits 2:1 carry word-address bits 9:8. Bit 0 is the direction, with 1 meaning read. For any other value of bits 7:3 the block gives no acknowledge and leaves memory and pointer untouched until the next start.
- R2: The block pulls SDA low (sda_oe_o = 1) during the ninth clock of every byte it accepts: a matching device byte, the word-address byte and each write data byte. It changes sda_oe_o only while the filtered SCL is low.
- R3: Each write data byte is stored at the pointer. After it, only pointer bits 3:0 increment, wrapping modulo 16, and bits 9:4 stay fixed. A single data byte is a byte write and several are a page write.
- R4: A read with no preceding address phase returns bytes starting at the pointer. The pointer always equals the last accessed address plus one (page-wrapped after writes) and persists across transactions. Device-byte bits 2:1 are ignored in reads.
- R5: A write device byte and word-address byte, then a repeated start and a read device byte, returns data starting from that word address.
- R6: Reads advance the full 10-bit pointer, wrapping from 1023 to 0, for as long as the master acknowledges. After a master no-acknowledge the block leaves SDA released.
- R7: A start (SDA falling while SCL is high) restarts byte framing from any state, and a partial data byte cut short by it is not stored. A stop (SDA rising while SCL is high) returns the block to idle with SDA released.
- R8: After a stop that ends a transaction in which at least one data byte was written, the device byte is not acknowledged and nothing is written for WR_BUSY_CYC clocks. After that the block acknowledges again.
- R9: A change on SCL or SDA that lasts fewer than FILT_LEN clocks has no effect on the transfer.
- R10: Under reset (synchronous, active low) SDA is released, the pointer is 0 and every memory byte is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Directed transfers cover each transfer type in turn:
- a single-byte write;
- a page write that crosses the end of its row, which shows whether the pointer's row bits stay fixed;
- a sequential read across address 1023, which shows whether read increments use the full pointer width;
- a current-address read whose device byte carries stray address bits;
- a foreign device ID, a write cut short by a repeated start, and a busy poll straight after a write, each followed by read-back to show that nothing changed.

A transfer carrying deliberate sub-threshold pulses on both lines must give the same result as a clean one. Seeded random writes, random reads and current reads of random lengths are then checked against a bench model of the array and pointer. This catches wrong pointer bookkeeping between transactions.

// File: rtl/twi_pkg.sv
// Shared types for the serial EEPROM slave.
package twi_pkg;

    // Transaction phase of the bus slave.
    typedef enum logic [2:0] {
        ST_IDLE,   // no transaction active
        ST_DEV,    // receiving device byte
        ST_WADDR,  // receiving low word-address byte
        ST_WDATA,  // receiving write data bytes
        ST_RDATA,  // sending read data bytes
        ST_SKIP    // not addressed or read ended; wait for start or stop
    } twi_state_t;

endpackage

// File: rtl/twi_pin_filter.sv
// Two-flop synchronizer followed by a persistence filter for one bus line.
// The output follows the synchronized input only after the input has
// differed from it for FILT_LEN consecutive clocks. Assumes an idle-high line.
module twi_pin_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic          sync_a, sync_b;
    logic [CW-1:0] run_cnt;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= pin_i;
            sync_b <= sync_a;
        end
    end

    // Accept a new level only after it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_o   <= 1'b1;
            run_cnt <= '0;
        end else if (sync_b == pin_o) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_LEN - 1)) begin
            pin_o   <= sync_b;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    // R9: a filtered transition always adopts the level the synchronizer showed.
    assert_filter_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_o != $past(pin_o)) |-> (pin_o == $past(sync_b)));

endmodule

// File: rtl/twi_cond_detect.sv
// Derives start, stop and clock-edge strobes from the filtered bus lines.
// Assumes both lines pass through filters of equal latency.
module twi_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    // Hold the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode bus events from the level pairs.
    always_comb begin
        start_o = scl_q & scl_f & sda_q & ~sda_f;
        stop_o  = scl_q & scl_f & ~sda_q & sda_f;
        rise_o  = ~scl_q & scl_f;
        fall_o  = scl_q & ~scl_f;
    end

endmodule

// File: rtl/twi_byte_array.sv
// Byte-wide storage of 2**AW flip-flop entries, cleared by reset,
// one synchronous write port and one combinational read port.
module twi_byte_array #(
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    // Clear on reset, otherwise store on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    // Read the entry under the pointer.
    assign rdata = cells[addr];

endmodule

// File: rtl/twi_eeprom_slave.sv
// Two-wire bus slave in front of a byte array. Handles device/word
// addressing, page-confined write increments, full-range read increments,
// acknowledge generation and a post-write busy window.
// Assumes the clock oversamples SCL so that each SCL phase lasts well
// over FILT_LEN + 3 clocks.
module twi_eeprom_slave
    import twi_pkg::*;
#(
    parameter int unsigned MEM_AW      = 10,
    parameter int unsigned PAGE_AW     = 4,
    parameter int unsigned FILT_LEN    = 3,
    parameter int unsigned WR_BUSY_CYC = 1000,
    parameter int unsigned DEV_ID      = 32'h14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam int unsigned HB     = MEM_AW - 8;
    localparam int unsigned IDW    = 7 - HB;
    localparam int unsigned BUSY_W = $clog2(WR_BUSY_CYC + 1);

    logic [1:0]        raw_lines, filt_lines;
    logic              scl_f, sda_f;
    logic              start_ev, stop_ev, scl_rise, scl_fall;
    twi_state_t        state;
    logic [3:0]        bit_cnt;
    logic              ack_ph;
    logic [7:0]        rx_sh, tx_byte, rd_byte;
    logic [MEM_AW-1:0] ptr;
    logic              wr_pend;
    logic [BUSY_W-1:0] busy_cnt;
    logic              mem_we;
    logic              active;

    assign raw_lines = {scl_i, sda_i};

    // One filter per bus line: [1] clock, [0] data.
    for (genvar g = 0; g < 2; g++) begin : g_line
        twi_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (raw_lines[g]),
            .pin_o (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    twi_cond_detect u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .start_o (start_ev),
        .stop_o  (stop_ev),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    twi_byte_array #(.AW(MEM_AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (rx_sh),
        .rdata (rd_byte)
    );

    // States in which bus edges are acted on.
    assign active = (state == ST_DEV) || (state == ST_WADDR) ||
                    (state == ST_WDATA) || (state == ST_RDATA);

    // Store a write byte when its eighth bit has been clocked in.
    assign mem_we = (state == ST_WDATA) && scl_fall && !ack_ph &&
                    (bit_cnt == 4'd8) && !start_ev && !stop_ev;

    // Bus transaction sequencer, pointer and busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            ack_ph   <= 1'b0;
            rx_sh    <= '0;
            tx_byte  <= '0;
            ptr      <= '0;
            wr_pend  <= 1'b0;
            busy_cnt <= '0;
            sda_oe_o <= 1'b0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - BUSY_W'(1);
            if (start_ev) begin
                state    <= ST_DEV;
                bit_cnt  <= '0;
                ack_ph   <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (stop_ev) begin
                state    <= ST_IDLE;
                ack_ph   <= 1'b0;
                sda_oe_o <= 1'b0;
                if (wr_pend) begin
                    busy_cnt <= BUSY_W'(WR_BUSY_CYC);
                    wr_pend  <= 1'b0;
                end
            end else if (active && scl_rise) begin
                if (ack_ph) begin
                    if (state == ST_RDATA && sda_f) state <= ST_SKIP;
                end else if (bit_cnt != 4'd8) begin
                    rx_sh   <= {rx_sh[6:0], sda_f};
                    bit_cnt <= bit_cnt + 4'd1;
                end
            end else if (active && scl_fall) begin
                if (ack_ph) begin
                    ack_ph  <= 1'b0;
                    bit_cnt <= '0;
                    if (state == ST_RDATA) begin
                        tx_byte  <= rd_byte;
                        sda_oe_o <= ~rd_byte[7];
                        ptr      <= ptr + MEM_AW'(1);
                    end else begin
                        sda_oe_o <= 1'b0;
                    end
                end else if (bit_cnt == 4'd8) begin
                    ack_ph <= 1'b1;
                    case (state)
                        ST_DEV: begin
                            if (rx_sh[7:HB+1] == IDW'(DEV_ID) && busy_cnt == '0) begin
                                sda_oe_o <= 1'b1;
                                if (rx_sh[0]) begin
                                    state <= ST_RDATA;
                                end else begin
                                    ptr[MEM_AW-1:8] <= rx_sh[HB:1];
                                    state           <= ST_WADDR;
                                end
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                        ST_WADDR: begin
                            ptr[7:0] <= rx_sh;
                            sda_oe_o <= 1'b1;
                            state    <= ST_WDATA;
                        end
                        ST_WDATA: begin
                            ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + PAGE_AW'(1);
                            wr_pend          <= 1'b1;
                            sda_oe_o         <= 1'b1;
                        end
                        default: sda_oe_o <= 1'b0;
                    endcase
                end else if (state == ST_RDATA && bit_cnt != 4'd0) begin
                    sda_oe_o <= ~tx_byte[3'(4'd7 - bit_cnt)];
                end
            end
        end
    end

    // R2: the slave starts driving the data line only while the clock is low.
    assert_drive_clk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_f);

    // R3: row bits of the pointer hold while a page write streams in.
    assert_row_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && $past(state) == ST_WDATA) |->
            $stable(ptr[MEM_AW-1:PAGE_AW]));

    // R8: no array write happens inside the busy window.
    assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != '0) |-> !mem_we);

    // R7: once idle, the data line is released.
    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_o);

endmodule

// File: tb/twi_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module twi_eeprom_slave_tb_top;
    localparam int unsigned QTR     = 10;
    localparam int unsigned BUSY    = 1000;
    localparam int unsigned DEPTH   = 1024;
    localparam logic [4:0]  ID      = 5'b10100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] mdl [DEPTH];
    int unsigned mptr = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twi_eeprom_slave #(.WR_BUSY_CYC(BUSY)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (QTR) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    // Send nb bits MSB first; glitch adds sub-threshold pulses on bit 4.
    task automatic send_bits(input logic [7:0] b, input int nb, input bit glitch);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; q();
            if (glitch && i == 4) begin
                scl_m = 1'b1; repeat (2) @(posedge clk); #1; scl_m = 1'b0; q();
            end
            scl_m = 1'b1; q();
            if (glitch && i == 4) begin
                sda_m = ~b[i]; repeat (2) @(posedge clk); #1; sda_m = b[i];
            end
            q(); scl_m = 1'b0; q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        send_bits(b, 8, glitch);
        sda_m = 1'b1; q(); scl_m = 1'b1; q();
        ack = !sda_line;
        q(); scl_m = 1'b0; q();
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
        end
        q(); sda_m = nack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
    endtask

    task automatic wait_busy();
        repeat (BUSY + 60) @(posedge clk);
        #1;
    endtask

    // Page write of n bytes from addr; the low nibble wraps inside the row (R3).
    task automatic page_write(input int unsigned addr, input int n, input bit glitch, input bit settle);
        bit ack;
        logic [7:0] d;
        int unsigned a;
        bus_start();
        send_byte({ID, 2'(addr >> 8), 1'b0}, 1'b0, ack); check("R1 dev ack write", ack, 1);
        send_byte(8'(addr), 1'b0, ack);                  check("R2 word addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            a = (addr & 32'h3F0) | ((addr + i) & 32'hF);
            send_byte(d, glitch, ack);                   check("R2 data ack", ack, 1);
            mdl[a] = d;
        end
        bus_stop();
        mptr = (addr & 32'h3F0) | ((addr + n) & 32'hF);
        if (settle) wait_busy();
    endtask

    // Read n bytes; random mode first loads the pointer with a dummy write (R5).
    task automatic read_seq(input bit rnd, input int unsigned addr, input int n,
                            input logic [1:0] stray, input string tag);
        bit ack;
        logic [7:0] b;
        if (rnd) begin
            bus_start();
            send_byte({ID, 2'(addr >> 8), 1'b0}, 1'b0, ack); check("R1 dummy dev ack", ack, 1);
            send_byte(8'(addr), 1'b0, ack);                  check("R5 dummy addr ack", ack, 1);
            mptr = addr;
        end
        bus_start();
        send_byte({ID, stray, 1'b1}, 1'b0, ack); check("R1 dev ack read", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            check(tag, b, mdl[mptr]);
            mptr = (mptr + 1) % DEPTH;
        end
        check("R6 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        bit ack;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
        repeat (5) @(posedge clk);
        #1;
        check("R10 sda released in reset", sda_oe, 0);
        rst_n = 1'b1;
        q();
        check("R10 sda released after reset", sda_oe, 0);

        // R10/R4: first current read sees cleared memory at pointer 0.
        read_seq(1'b0, 0, 1, 2'b00, "R10 cleared memory at pointer 0");

        // R3 byte write then R5 random read-back.
        page_write(32'h123, 1, 1'b0, 1'b1);
        read_seq(1'b1, 32'h123, 1, 2'b00, "R5 random read of byte write");

        // R3 page write crossing the row end wraps to the row start.
        page_write(32'h2FC, 6, 1'b0, 1'b1);
        check("R3 wrapped byte at row start", mdl[32'h2F1] != 8'h00 || mdl[32'h2F0] != 8'h00, 1);
        read_seq(1'b1, 32'h2F0, 16, 2'b00, "R3 row contents after wrap");

        // R4: current read continues from pointer; device bits 2:1 ignored.
        page_write(32'h2A0, 3, 1'b0, 1'b1);
        read_seq(1'b0, 0, 2, 2'b11, "R4 current read from pointer");
        read_seq(1'b0, 0, 1, 2'b01, "R4 pointer persists between transactions");

        // R1: foreign device ID gets no ack and changes nothing.
        bus_start();
        send_byte(8'hB2, 1'b0, ack); check("R1 foreign id nack", ack, 0);
        send_byte(8'h23, 1'b0, ack); check("R1 foreign id ignored", ack, 0);
        send_byte(8'h5A, 1'b0, ack);
        bus_stop();
        read_seq(1'b1, 32'h123, 1, 2'b00, "R1 memory untouched by foreign id");

        // R8: polling right after a write is refused, later accepted.
        page_write(32'h040, 2, 1'b0, 1'b0);
        bus_start();
        send_byte({ID, 2'b00, 1'b1}, 1'b0, ack); check("R8 busy poll nack", ack, 0);
        bus_stop();
        wait_busy();
        read_seq(1'b0, 0, 1, 2'b00, "R8 read after busy window");

        // R6: sequential read wraps 1023 -> 0.
        page_write(32'h3FE, 2, 1'b0, 1'b1);
        page_write(32'h000, 2, 1'b0, 1'b1);
        read_seq(1'b1, 32'h3FE, 4, 2'b00, "R6 sequential wrap across top");

        // R9: sub-threshold pulses on SCL and SDA leave the transfer intact.
        page_write(32'h1B7, 3, 1'b1, 1'b1);
        read_seq(1'b1, 32'h1B7, 3, 2'b00, "R9 data after glitches");

        // R7: a start in mid data byte discards the partial byte.
        bus_start();
        send_byte({ID, 2'b01, 1'b0}, 1'b0, ack); check("R7 dev ack", ack, 1);
        send_byte(8'h23, 1'b0, ack);             check("R7 addr ack", ack, 1);
        send_bits(8'hC3, 4, 1'b0);
        mptr = 32'h123;
        bus_start();
        send_byte({ID, 2'b00, 1'b1}, 1'b0, ack); check("R7 restart read ack", ack, 1);
        begin
            logic [7:0] b;
            recv_byte(1'b1, b);
            check("R7 aborted byte not stored", b, mdl[32'h123]);
            mptr = 32'h124;
        end
        bus_stop();
        q();
        check("R7 released after stop", sda_oe, 0);

        // Seeded random mix checked against the model.
        for (int it = 0; it < 10; it++) begin
            int op;
            int unsigned a;
            op = int'($urandom_range(0, 2));
            a  = $urandom_range(0, DEPTH - 1);
            case (op)
                0: page_write(a, int'($urandom_range(1, 18)), 1'b0, 1'b1);
                1: read_seq(1'b1, a, int'($urandom_range(1, 6)), 2'b00, "R5 random read");
                default: read_seq(1'b0, 0, int'($urandom_range(1, 6)), 2'(a), "R4 random current read");
            endcase
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule